// File: doc/BRIEF.md
# Programmable Periodic Tick Generator

This block turns a 32768 Hz time base, delivered as a one-cycle enable on the system clock, into a programmable periodic tick. An 8-bit control byte holds a 4-bit rate code and a 3-bit divider-control field. The rate code picks the tick period. The divider-control field either lets the phase counter run or holds it cleared. A separate enable input decides whether ticks happen at all and whether they request an interrupt. Each tick produces a one-cycle flag pulse and, when enabled, a one-cycle interrupt request pulse.

The phase counter counts time-base enables since the last tick. A change of rate code does not restart it, so the next tick lands one new period after the previous tick. If that moment has already passed, the tick comes on the next time-base enable. Holding the divider, clearing the rate code or dropping the enable all clear the counter. Counting then resumes from zero.

Top module: `periodic_tick_gen`

## Requirements
- R1: After a synchronous reset the control byte equals parameter CTRL_RESET (default 8'h26), the phase counter is zero, and both pulse outputs are low.
- R2: The tick period, counted in time-base enables, is 128 for rate code 1, 256 for rate code 2, and 2^(code-1) for codes 3 to 15. The rate code is control bits [3:0].
- R3: Rate code 0 produces no pulses.
- R4: While `pie` is low the period is taken as zero. No pulse is produced and the phase counter stays at zero, so the first tick after `pie` rises comes one full period later.
- R5: With a nonzero period, `pf_pulse` is high for exactly one cycle. This is the cycle after the clock edge at which a time-base enable completes the period.
- R6: `irq_pulse` is high exactly when `pf_pulse` is high and `pie` was high at the edge that produced the tick. It is never high without `pf_pulse`.
- R7: A write with `cfg_we` high loads `cfg_wdata` into the control byte at the clock edge. The new value takes effect from the following edge. Control bits [6:5] equal to 2'b11 hold the divider.
- R8: When the rate code changes, the next tick comes one new period after the previous tick. If at least one new period has already elapsed, the tick comes at the next time-base enable.
- R9: While the divider is held, the phase counter stays at zero and no pulse is produced. After release the first tick comes one full period later.
- R10: A pulse appears only in the cycle after an edge at which `tick_en` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data: [3:0] rate code, [6:4] divider control |
| pie | input | 1 | Periodic interrupt enable |
| pf_pulse | output | 1 | One-cycle periodic flag pulse |
| irq_pulse | output | 1 | One-cycle periodic interrupt request pulse |

## Verification
The assertions assume that `tick_en` is a single-cycle enable at the system-clock edge and that every input is synchronous to `clk`. They also assume that the shortest period, four enables, separates any two ticks, which is why a pulse is never followed by a second one in the next cycle. The stimulus drives all inputs at the falling edge and writes the control byte with one-cycle strobes. It uses time-base patterns of every cycle and every third cycle, so enables are sometimes back to back and sometimes spaced out. Rate changes are issued at known counts after a tick, so the re-based delay can be predicted exactly.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int RATE_W = 4;
    localparam int CTRL_W = 8;
    // longest period is 2^((1<<RATE_W)-2) enables
    localparam int CNT_W  = (1 << RATE_W) - 2;
    localparam int PER_W  = CNT_W + 1;

    typedef struct packed {
        logic              spare;
        logic [2:0]        dvc;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic flag;
        logic req;
    } pulse_t;

    function automatic logic [PER_W-1:0] rate_period(input logic [RATE_W-1:0] code);
        logic [PER_W-1:0] p;
        if (code == '0)
            p = '0;
        else if (code == RATE_W'(1))
            p = PER_W'(128);
        else if (code == RATE_W'(2))
            p = PER_W'(256);
        else
            p = PER_W'(1) << (code - RATE_W'(1));
        return p;
    endfunction

    function automatic logic divider_held(input ctrl_t c);
        return c.dvc[2:1] == 2'b11;
    endfunction

endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
    import pit_pkg::*;
#(
    parameter logic [CTRL_W-1:0] CTRL_RESET = 8'h26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              pie,
    output logic [PER_W-1:0]  period,
    output logic              hold
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (we)
            ctrl_q <= ctrl_t'(wdata);
    end

    always_comb begin
        hold   = divider_held(ctrl_q);
        period = pie ? rate_period(ctrl_q.rate) : '0;
    end

endmodule

// File: rtl/pit_phase_counter.sv
module pit_phase_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [PER_W-1:0] period,
    input  logic             hold,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             idle;
    logic             due;

    always_comb begin
        idle = hold || (period == '0);
        due  = ({1'b0, cnt_q} >= (period - PER_W'(1)));
        fire = tick_en && !idle && due;
    end

    always_ff @(posedge clk) begin
        if (rst || idle)
            cnt_q <= '0;
        else if (tick_en) begin
            if (due)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R9: a held divider leaves the counter at zero
    assert_hold_clears_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt_q == '0));

    // R4: a zero period leaves the counter at zero
    assert_zero_period_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pit_out_stage.sv
module pit_out_stage
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic pie,
    output logic pf_pulse,
    output logic irq_pulse
);

    pulse_t out_q;

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else begin
            out_q.flag <= fire;
            out_q.req  <= fire && pie;
        end
    end

    assign pf_pulse  = out_q.flag;
    assign irq_pulse = out_q.req;

    // R6: no request without a flag
    assert_req_implies_flag_R6: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> pf_pulse);

    // R5: the flag lasts one cycle
    assert_flag_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        pf_pulse |=> !pf_pulse);

endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
    import pit_pkg::*;
#(
    parameter logic [7:0] CTRL_RESET = 8'h26
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       pie,
    output logic       pf_pulse,
    output logic       irq_pulse
);

    logic [PER_W-1:0] period;
    logic             hold;
    logic             fire;

    pit_ctrl_reg #(.CTRL_RESET(CTRL_RESET)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .pie    (pie),
        .period (period),
        .hold   (hold)
    );

    pit_phase_counter u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .period  (period),
        .hold    (hold),
        .fire    (fire)
    );

    pit_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .pie       (pie),
        .pf_pulse  (pf_pulse),
        .irq_pulse (irq_pulse)
    );

    // R10: pulses follow a time-base enable
    assert_pulse_needs_tick_R10: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> !pf_pulse);

    // R9: nothing fires while held
    assert_no_pulse_held_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> !pf_pulse);

    // R3: a zero period never fires
    assert_no_pulse_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> !pf_pulse);

endmodule

// File: tb/periodic_tick_gen_test.sv
module periodic_tick_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CTRL   = 'h26;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       pie = 1'b0;
    logic       pf_pulse;
    logic       irq_pulse;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    int  tick_div = 1;
    int  tick_ph  = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_ctrl = RST_CTRL;
    int m_elapsed = 0;
    bit m_pf = 0;
    bit m_irq = 0;

    periodic_tick_gen uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .pie       (pie),
        .pf_pulse  (pf_pulse),
        .irq_pulse (irq_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_period(int code, bit en);
        if (!en || code == 0) return 0;
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // reference model, evaluated from pre-edge inputs
    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = RST_CTRL; m_elapsed = 0; m_pf = 0; m_irq = 0;
        end else begin
            int per;
            bit held;
            bit f;
            per  = ref_period(m_ctrl & 'hf, pie);
            held = ((m_ctrl >> 5) & 3) == 3;
            f = 0;
            if (held || per == 0) m_elapsed = 0;
            else if (tick_en) begin
                if (m_elapsed + 1 >= per) begin m_elapsed = 0; f = 1; end
                else m_elapsed++;
            end
            m_pf = f;
            m_irq = f && pie;
            if (cfg_we) m_ctrl = cfg_wdata;
        end
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // time-base enable pattern
    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % tick_div;
        tick_en <= (tick_ph == 0);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(pf_pulse === m_pf, {cur_req, " pf"}, pf_pulse, m_pf);
            check(irq_pulse === m_irq, {cur_req, " irq"}, irq_pulse, m_irq);
        end
    end

    task automatic wr(int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic count(int n, output int npf, output int nirq);
        npf = 0; nirq = 0;
        repeat (n) begin
            @(negedge clk);
            #1;
            npf += pf_pulse;
            nirq += irq_pulse;
        end
    endtask

    task automatic wait_pulse();
        int k = 0;
        while (k < 2000) begin
            @(negedge clk); #1;
            if (pf_pulse) break;
            k++;
        end
    endtask

    // write at a negedge, then count negedges until the flag
    task automatic write_and_measure(int v, output int n);
        n = 0;
        cfg_we = 1'b1; cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        n = 1; #1;
        while (!pf_pulse && n < 2000) begin
            @(negedge clk); #1;
            n++;
        end
    endtask

    initial begin
        int a, b, n;
        repeat (3) @(negedge clk);
        #1;
        check(pf_pulse === 1'b0 && irq_pulse === 1'b0, "R1 outputs", pf_pulse, 0);
        rst = 1'b0;

        // R5/R6: default rate 6 (32 enables), every cycle
        cur_req = "R5"; pie = 1'b1;
        count(100, a, b);
        check(a == 3, "R5 pulse count", a, 3);
        check(b == 3, "R6 irq count", b, 3);

        // R9/R7: hold, then release with rate 3
        cur_req = "R9";
        wr('h63);
        count(30, a, b);
        check(a == 0, "R9 held no pulse", a, 0);
        @(negedge clk);
        write_and_measure('h23, n);
        check(n == 5, "R9 first tick after release", n, 5);

        // R2: rate 3, rate 1, rate 2
        cur_req = "R2";
        wr('h63); @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h23; @(negedge clk); cfg_we = 1'b0;
        count(41, a, b);
        check(a == 10, "R2 code 3 count", a, 10);
        wr('h61); wr('h21);
        count(300, a, b);
        check(a == 2, "R2 code 1 count", a, 2);
        wr('h62); wr('h22);
        count(300, a, b);
        check(a == 1, "R2 code 2 count", a, 1);

        // R3: rate code zero
        cur_req = "R3";
        wr('h20);
        count(100, a, b);
        check(a == 0, "R3 code 0 silent", a, 0);

        // R4: enable low, then first tick a full period after rise
        cur_req = "R4";
        wr('h23); pie = 1'b0;
        count(50, a, b);
        check(a == 0 && b == 0, "R4 disabled silent", a, 0);
        pie = 1'b1;
        n = 0; #1;
        while (!pf_pulse && n < 100) begin @(negedge clk); #1; n++; end
        check(n == 4, "R4 first tick after enable", n, 4);

        // R8: re-base on rate change
        cur_req = "R8";
        wr('h25);
        wait_pulse();
        repeat (5) @(negedge clk);
        write_and_measure('h24, n);
        check(n == 3, "R8 rebase later tick", n, 3);
        wr('h25);
        wait_pulse();
        repeat (5) @(negedge clk);
        write_and_measure('h23, n);
        check(n == 2, "R8 overdue tick immediate", n, 2);

        // R10: sparse time base
        cur_req = "R10";
        tick_div = 3;
        count(120, a, b);
        check(a >= 8 && a <= 11, "R10 sparse count", a, 10);
        tick_div = 1;

        // R7: reset value restored by reset
        cur_req = "R7";
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        count(35, a, b);
        check(a == 1, "R7 reset rate restored", a, 1);

        finish_run();
    end

endmodule